// File: doc/BRIEF.md
# Modulo Circular-Buffer Address Generator

This block produces the read/write address for a delay line kept as a ring inside ordinary RAM. Software sets up a window that starts at a base word and spans a given number of contiguous words. It also sets a current pointer and a signed stride. Each advance request moves the pointer by the stride. When the pointer steps past the top of the window, it folds back down by the window length. When it steps below the base, it folds up by the same amount. Filter code therefore never shifts samples and never tests pointer bounds itself.

A fold in either direction produces two signals. The first is a one-cycle wrap strobe. The second is a sticky interrupt request, which stays high until software clears it. All configuration goes through a single write port made of an enable, a register select and a data word. The memory array and any arithmetic on the samples lie outside the block.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, `addr` is 0 and `wrapPulse` and `irq` are both low.
- R2: The write port decodes `wrSel` as follows: 0 = base, 1 = length, 2 = pointer, 3 = stride, 4 = interrupt clear. Select values 5 to 7 change nothing. The stride is the full `wrData` word read as two's complement. The base, length and pointer take the low ADDR_W bits.
- R3: A pointer write shows on `addr` one cycle later. No fold is applied, even when the value lies outside the window, and `wrapPulse` stays low.
- R4: An advance whose sum (pointer + stride) stays inside [base, base+length) moves `addr` to that sum on the next cycle.
- R5: With a positive stride, a sum at or above base+length is reduced by the length.
- R6: With a negative stride, a sum below base is raised by the length.
- R7: `wrapPulse` is high for exactly the cycle after an advance that folded, and low after every other cycle.
- R8: `irq` rises together with `wrapPulse` and then holds. It falls only after a write to select 4 with `wrData[0]` = 1. A clear write with bit 0 = 0 leaves it set.
- R9: If `advance` and `wrEn` are high in the same cycle, only the write takes effect.
- R10: A stride of magnitude equal to the length folds on every advance and leaves `addr` unchanged.
- R11: If the pointer starts inside the window and 0 < |stride| ≤ length, every advance keeps it inside the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Step the pointer by the stride this cycle |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 3 | Register select (R2) |
| wrData | input | ADDR_W+1 | Write data |
| addr | output | ADDR_W | Current pointer used as the RAM address |
| wrapPulse | output | 1 | One-cycle fold strobe |
| irq | output | 1 | Sticky interrupt request |

## Verification
On every cycle, the assertions check these properties:
- the pointer stays inside the window under legal strides;
- the interrupt is held and released as specified;
- a write blocks the strobe;
- a pointer write lands verbatim.

Only the bench scenarios can show the exact folded address values for each base, length, start point and stride. The same applies to the full-length stride case, the ignored select codes and the effect of a clear write carrying bit 0 = 0. The bench sweeps every start point and every legal stride for lengths 1 to 8 at three bases, including a window that ends at the top of the address space.

// File: rtl/circ_addr_pkg.sv
package circ_addr_pkg;
  localparam logic [2:0] SEL_BASE = 3'd0;
  localparam logic [2:0] SEL_LEN  = 3'd1;
  localparam logic [2:0] SEL_IDX  = 3'd2;
  localparam logic [2:0] SEL_STEP = 3'd3;
  localparam logic [2:0] SEL_CLR  = 3'd4;

  typedef struct packed {
    logic ldBase;
    logic ldLen;
    logic ldIdx;
    logic ldStep;
    logic stepEn;
    logic clrIrq;
  } ctl_strobe_t;
endpackage

// File: rtl/circ_addr_ctrl.sv
module circ_addr_ctrl
  import circ_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        advance,
  input  logic        wrEn,
  input  logic [2:0]  wrSel,
  input  logic        clrBit,
  input  logic        wrapHit,
  output ctl_strobe_t strb,
  output logic        wrapPulse,
  output logic        irq
);
  // write decode; a write always blocks the advance (R9)
  always_comb begin
    strb        = '0;
    strb.ldBase = wrEn && (wrSel == SEL_BASE);
    strb.ldLen  = wrEn && (wrSel == SEL_LEN);
    strb.ldIdx  = wrEn && (wrSel == SEL_IDX);
    strb.ldStep = wrEn && (wrSel == SEL_STEP);
    strb.clrIrq = wrEn && (wrSel == SEL_CLR) && clrBit;
    strb.stepEn = advance && !wrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrapPulse <= 1'b0;
      irq       <= 1'b0;
    end else begin
      wrapPulse <= strb.stepEn && wrapHit;
      if (strb.stepEn && wrapHit) irq <= 1'b1;
      else if (strb.clrIrq)       irq <= 1'b0;
    end
  end

  assert_irq_follows_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> irq);
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !strb.clrIrq) |=> irq);
  assert_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrIrq |=> !irq);
  assert_write_blocks_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrapPulse);
endmodule

// File: rtl/circ_addr_dp.sv
module circ_addr_dp
  import circ_addr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strb,
  input  logic [ADDR_W:0]   wrData,
  output logic              wrapHit,
  output logic [ADDR_W-1:0] idx
);
  localparam int SW = ADDR_W + 2;

  logic [ADDR_W-1:0] baseR, lenR;
  logic [ADDR_W:0]   stepR;
  logic signed [SW-1:0] idxW, stepW, baseW, lenW, limitW, sumW, nextW;
  logic stepPos, stepNeg, wrapUp, wrapDn;

  always_comb begin
    idxW    = signed'({2'b00, idx});
    baseW   = signed'({2'b00, baseR});
    lenW    = signed'({2'b00, lenR});
    stepW   = signed'({stepR[ADDR_W], stepR});
    limitW  = baseW + lenW;
    sumW    = idxW + stepW;
    stepNeg = stepR[ADDR_W];
    stepPos = !stepR[ADDR_W] && (stepR != '0);
    wrapUp  = stepPos && (sumW >= limitW);
    wrapDn  = stepNeg && (sumW < baseW);
    wrapHit = wrapUp || wrapDn;
    if (wrapUp)      nextW = sumW - lenW;
    else if (wrapDn) nextW = sumW + lenW;
    else             nextW = sumW;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseR <= '0;
      lenR  <= '0;
      stepR <= '0;
      idx   <= '0;
    end else begin
      if (strb.ldBase) baseR <= wrData[ADDR_W-1:0];
      if (strb.ldLen)  lenR  <= wrData[ADDR_W-1:0];
      if (strb.ldStep) stepR <= wrData;
      if (strb.ldIdx)       idx <= wrData[ADDR_W-1:0];
      else if (strb.stepEn) idx <= nextW[ADDR_W-1:0];
    end
  end

  // checker-side view of the window, independent of the fold arithmetic
  logic inWin, stepOk;
  logic [ADDR_W:0] magStep;
  always_comb begin
    magStep = stepR[ADDR_W] ? (~stepR + 1'b1) : stepR;
    stepOk  = (stepR != '0) && ({1'b0, magStep} <= {2'b00, lenR});
    inWin   = ({1'b0, idx} >= {1'b0, baseR}) &&
              ({1'b0, idx} < ({1'b0, baseR} + {1'b0, lenR}));
  end

  assert_stays_in_window_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepEn && inWin && stepOk) |=> inWin);
  assert_index_load_verbatim_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldIdx |=> (idx == $past(wrData[ADDR_W-1:0])));
  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ldIdx && !strb.stepEn) |=> $stable(idx));
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import circ_addr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [ADDR_W:0]   wrData,
  output logic [ADDR_W-1:0] addr,
  output logic              wrapPulse,
  output logic              irq
);
  ctl_strobe_t strb;
  logic wrapHit;

  circ_addr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .advance(advance), .wrEn(wrEn), .wrSel(wrSel),
    .clrBit(wrData[0]), .wrapHit(wrapHit), .strb(strb),
    .wrapPulse(wrapPulse), .irq(irq)
  );

  circ_addr_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .wrapHit(wrapHit), .idx(addr)
  );
endmodule

// File: tb/circ_addr_gen_tb.sv
module circ_addr_gen_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic advance = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrSel = 3'd0;
  logic [W:0] wrData = '0;
  logic [W-1:0] addr;
  logic wrapPulse, irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  circ_addr_gen #(.ADDR_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .advance(advance), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .addr(addr), .wrapPulse(wrapPulse), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'(sel); wrData = (W+1)'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic adv();
    @(negedge clk);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bases[3] = '{0, 37, 248};
    repeat (3) @(negedge clk);
    chk("R1 addr", addr, 0);
    chk("R1 wrapPulse", wrapPulse, 0);
    chk("R1 irq", irq, 0);
    rstN = 1'b1;

    // exhaustive sweep: bases x lengths x strides x start points
    foreach (bases[bi]) begin
      for (int l = 1; l <= 8; l++) begin
        wr(0, bases[bi]);
        wr(1, l);
        for (int m = -l; m <= l; m++) begin
          if (m == 0) continue;
          wr(3, m);
          for (int s = 0; s < l; s++) begin
            int i0, e;
            bit w;
            i0 = bases[bi] + s;
            wr(4, 1);
            wr(2, i0);
            chk("R3 load", addr, i0);
            chk("R3 nowrap", wrapPulse, 0);
            e = i0 + m; w = 0;
            if (m > 0 && e >= bases[bi] + l) begin e -= l; w = 1; end
            if (m < 0 && e < bases[bi]) begin e += l; w = 1; end
            adv();
            if (!w) chk("R4 step", addr, e);
            else if (m > 0) chk("R5 upwrap", addr, e);
            else chk("R6 downwrap", addr, e);
            chk("R7 pulse", wrapPulse, int'(w));
            chk("R8 irq set", irq, int'(w));
            if (m == l || m == -l) chk("R10 fullstep", addr, i0);
            @(negedge clk);
            chk("R7 single", wrapPulse, 0);
            chk("R8 held", irq, int'(w));
          end
        end
      end
    end

    // R10: repeated full-length stride folds each time
    wr(0, 10); wr(1, 5); wr(3, -5); wr(2, 12); wr(4, 1);
    for (int k = 0; k < 3; k++) begin
      adv();
      chk("R10 addr", addr, 12);
      chk("R10 pulse", wrapPulse, 1);
    end

    // R8: clear with bit0=0 keeps irq; sticky across a non-wrapping step
    wr(3, 1); wr(2, 10);
    adv();
    chk("R8 sticky", irq, 1);
    chk("R7 no pulse", wrapPulse, 0);
    wr(4, 2);
    chk("R8 clr bit0=0", irq, 1);
    wr(4, 1);
    chk("R8 cleared", irq, 0);

    // R3: pointer write outside window is not folded
    wr(2, 40);
    chk("R3 outside", addr, 40);
    chk("R3 pulse", wrapPulse, 0);

    // R2: unused selects change nothing
    wr(2, 14);
    wr(5, 3); wr(6, 3); wr(7, 3);
    chk("R2 unused", addr, 14);
    adv();
    chk("R2 regs kept", addr, 10);
    chk("R2 wrap", wrapPulse, 1);
    wr(4, 1);

    // R9: write wins over advance
    wr(2, 14);
    @(negedge clk);
    advance = 1'b1; wrEn = 1'b1; wrSel = 3'd2; wrData = (W+1)'(11);
    @(negedge clk);
    advance = 1'b0; wrEn = 1'b0;
    chk("R9 addr", addr, 11);
    chk("R9 pulse", wrapPulse, 0);
    chk("R9 irq", irq, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule